// File: doc/BRIEF.md
# Symbol-Matrix Corrected Memory

This block is a small word memory that protects each 32-bit entry against single-bit upsets and against clusters of flipped cells. On a write, the word is cut into eight 4-bit symbols arranged as two rows of four columns. Two kinds of check bits are computed and stored beside the data. The horizontal checks are 5-bit unsigned integer sums of symbol pairs in the same row: column 0 is paired with column 2, and column 1 with column 3. The vertical checks are the 4-bit XOR of the two symbols stacked in each column. Together they give 36 check bits per word.

On a read, the decoder recomputes both check sets from the stored data. It forms arithmetic horizontal syndromes (recomputed sum minus stored sum, modulo 32) and XOR vertical syndromes. A symbol is treated as wrong when both its pair's horizontal syndrome and its column's vertical syndrome are nonzero. That symbol is then inverted on the bits that the vertical syndrome marks. The corrected word and an error flag come out of a register one cycle after the read request.

A flip mask on the write port XORs upsets into the stored data bits, leaving the check bits as computed from the clean word. This lets upsets be planted through the block's own interface. Symbol s occupies data bits [4s+3:4s], sits in row s/4 and in column s%4.

Top module: `dmc_protector`

## Requirements
- R1: A synchronous active-high reset clears rd_data and rd_err to zero and clears every stored word, so any address read after reset returns zero with rd_err low.
- R2: A word written with a zero flip mask reads back unchanged with rd_err low. rd_data and rd_err take their new value on the first rising edge after rd_en is sampled high. This holds for every value, including all-ones, where the symbol sums reach 30.
- R3: A write whose flip mask has exactly one bit set reads back as the original word, with rd_err high.
- R4: A write whose flip mask is a run of 2 to 4 adjacent set bits inside one symbol (bits [4s+3:4s]) reads back as the original word, with rd_err high.
- R5: A write whose flip mask touches exactly two symbols reads back as the original word, with rd_err high, provided one symbol lies in column 0 or 2 and the other in column 1 or 3 (in either row, any nonzero pattern in each).
- R6: With wr_en low, wr_data and wr_flip have no effect on the stored contents.
- R7: With rd_en low, rd_data and rd_err hold their values whatever rd_addr does.
- R8: A read and a write to the same address in the same cycle return the contents from before that write; the new word is visible to the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Word to encode and store |
| wr_flip | input | 32 | Upset mask XORed into the stored data bits on write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Corrected word, registered |
| rd_err | output | 1 | High when any syndrome bit of the read word was nonzero |

## Verification
Clean words include all-zero, all-ones and alternating patterns alongside random values. They show that neither the carry out of the 5-bit sums nor any column pattern produces a false flag. Random single-bit flips over all 32 positions show that each position maps to exactly one symbol and one bit. Random adjacent bursts inside one symbol show that the vertical syndrome carries the whole flip pattern. Random two-symbol upsets split across the two column pairs show that the pair sums and the column XORs select only the damaged symbols, and never their row or column neighbours. Directed cases on write suppression, read hold and same-cycle read-write ordering separate the port timing from the correction logic.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int SYM_W  = 4;
    localparam int ROWS   = 2;
    localparam int COLS   = 4;
    localparam int PAIRS  = COLS / 2;
    localparam int NSYM   = ROWS * COLS;
    localparam int DATA_W = NSYM * SYM_W;
    localparam int HSUM_W = SYM_W + 1;
    localparam int H_W    = ROWS * PAIRS * HSUM_W;
    localparam int V_W    = COLS * SYM_W;
    localparam int CHK_W  = H_W + V_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic [H_W-1:0] horiz;
        logic [V_W-1:0] vert;
    } chk_t;

    typedef struct packed {
        chk_t  chk;
        word_t data;
    } cell_t;

    function automatic logic [SYM_W-1:0] sym_at(input word_t w, input int r, input int c);
        return w[(r*COLS + c)*SYM_W +: SYM_W];
    endfunction

    function automatic chk_t calc_checks(input word_t w);
        chk_t res;
        res = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < PAIRS; k++) begin
                res.horiz[(r*PAIRS + k)*HSUM_W +: HSUM_W] =
                    {1'b0, sym_at(w, r, k)} + {1'b0, sym_at(w, r, k + PAIRS)};
            end
        end
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                res.vert[c*SYM_W +: SYM_W] = res.vert[c*SYM_W +: SYM_W] ^ sym_at(w, r, c);
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/dmc_encoder.sv
module dmc_encoder
    import dmc_pkg::*;
(
    input  word_t data_in,
    input  word_t flip_in,
    output cell_t cell_out
);
    always_comb begin
        cell_out.chk  = calc_checks(data_in);
        cell_out.data = data_in ^ flip_in;
    end
endmodule

// File: rtl/dmc_store.sv
module dmc_store
    import dmc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  cell_t             wcell,
    input  logic [ADDR_W-1:0] raddr,
    output cell_t             rcell
);
    cell_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wcell;
        end
    end

    assign rcell = mem[raddr];
endmodule

// File: rtl/dmc_decoder.sv
module dmc_decoder
    import dmc_pkg::*;
(
    input  cell_t cell_in,
    output word_t data_out,
    output logic  err_out
);
    chk_t  recomp;
    chk_t  syn;
    word_t fix_mask;

    always_comb begin
        recomp = calc_checks(cell_in.data);
        syn.vert = recomp.vert ^ cell_in.chk.vert;
        for (int f = 0; f < ROWS*PAIRS; f++) begin
            syn.horiz[f*HSUM_W +: HSUM_W] =
                recomp.horiz[f*HSUM_W +: HSUM_W] - cell_in.chk.horiz[f*HSUM_W +: HSUM_W];
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int FIELD = r*PAIRS + (c % PAIRS);
            logic pair_hit;
            assign pair_hit = |syn.horiz[FIELD*HSUM_W +: HSUM_W];
            assign fix_mask[(r*COLS + c)*SYM_W +: SYM_W] =
                pair_hit ? syn.vert[c*SYM_W +: SYM_W] : '0;
        end
    end

    assign data_out = cell_in.data ^ fix_mask;
    assign err_out  = |syn;
endmodule

// File: rtl/dmc_protector.sv
module dmc_protector
    import dmc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       wr_flip,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              rd_err
);
    cell_t enc_cell;
    cell_t raw_cell;
    word_t dec_data;
    logic  dec_err;

    dmc_encoder u_enc (
        .data_in (wr_data),
        .flip_in (wr_flip),
        .cell_out(enc_cell)
    );

    dmc_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .waddr(wr_addr),
        .wcell(enc_cell),
        .raddr(rd_addr),
        .rcell(raw_cell)
    );

    dmc_decoder u_dec (
        .cell_in (raw_cell),
        .data_out(dec_data),
        .err_out (dec_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else if (rd_en) begin
            rd_data <= dec_data;
            rd_err  <= dec_err;
        end
    end
endmodule

// File: rtl/dmc_protector_chk.sv
module dmc_protector_chk
    import dmc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       wr_flip,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic              rd_err
);
    logic [31:0]      shadow [DEPTH];
    logic [DEPTH-1:0] dirty;
    logic [DEPTH-1:0] one_sym;
    logic [NSYM-1:0]  sym_nz;
    logic [31:0]      exp_q;
    logic             clean_q;
    logic             fix_q;

    always_comb begin
        for (int s = 0; s < NSYM; s++) begin
            sym_nz[s] = |wr_flip[s*SYM_W +: SYM_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                shadow[i] <= '0;
            end
            dirty   <= '0;
            one_sym <= '0;
            exp_q   <= '0;
            clean_q <= 1'b0;
            fix_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                shadow[wr_addr]  <= wr_data;
                dirty[wr_addr]   <= |wr_flip;
                one_sym[wr_addr] <= ($countones(sym_nz) == 1);
            end
            clean_q <= rd_en && !dirty[rd_addr];
            fix_q   <= rd_en && one_sym[rd_addr];
            exp_q   <= shadow[rd_addr];
        end
    end

    assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0 && !rd_err));

    assert_clean_read_R2: assert property (@(posedge clk) disable iff (rst)
        clean_q |-> (rd_data == exp_q && !rd_err));

    assert_upset_flagged_R3: assert property (@(posedge clk) disable iff (rst)
        fix_q |-> rd_err);

    assert_symbol_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        fix_q |-> (rd_data == exp_q));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_en) && !$past(rst)) |-> ($stable(rd_data) && $stable(rd_err)));
endmodule

bind dmc_protector dmc_protector_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wr_flip(wr_flip),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .rd_err (rd_err)
);

// File: tb/dmc_protector_bench.sv
module dmc_protector_bench;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       wr_flip = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              rd_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    dmc_protector #(.DEPTH(DEPTH)) u_dmc_protector (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_flip(wr_flip),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err)
    );

    // Adjacent run of len bits starting at bit st inside symbol s
    function automatic logic [31:0] burst_mask(input int s, input int st, input int len);
        logic [31:0] m = '0;
        for (int b = 0; b < len; b++) m[s*4 + st + b] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] sym_mask(input int r, input int c, input logic [3:0] pat);
        logic [31:0] m = '0;
        m[(r*4 + c)*4 +: 4] = pat;
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] got_d, input logic [31:0] exp_d,
                         input logic got_e, input logic exp_e);
        n_checks++;
        if (got_d !== exp_d || got_e !== exp_e) begin
            n_fail++;
            $display("FAIL %s: data %h err %b, expected data %h err %b",
                     req, got_d, got_e, exp_d, exp_e);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_flip = m;
        @(negedge clk);
        wr_en = 1'b0; wr_flip = '0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr_rd(input string req, input logic [31:0] d, input logic [31:0] m);
        logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(DEPTH-1));
        do_write(a, d, m);
        do_read(a);
        check(req, rd_data, d, rd_err, m != 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values and cleared contents
        check("R1 outputs", rd_data, '0, rd_err, 1'b0);
        for (int a = 0; a < DEPTH; a++) begin
            do_read(ADDR_W'(a));
            check("R1 cleared word", rd_data, '0, rd_err, 1'b0);
        end
        // R2: clean words, directed and random
        wr_rd("R2 all ones", 32'hFFFF_FFFF, '0);
        wr_rd("R2 alternating", 32'hA5A5_5A5A, '0);
        wr_rd("R2 zero", 32'h0, '0);
        for (int i = 0; i < 40; i++) wr_rd("R2 random clean", $urandom, '0);
        // R3: single-bit flips over all positions
        for (int b = 0; b < 32; b++) wr_rd("R3 single flip", $urandom, 32'h1 << b);
        wr_rd("R3 flip on all ones", 32'hFFFF_FFFF, 32'h8000_0000);
        // R4: adjacent bursts within one symbol
        for (int i = 0; i < 60; i++) begin
            int len = $urandom_range(4, 2);
            int st  = $urandom_range(4 - len, 0);
            wr_rd("R4 burst", $urandom, burst_mask($urandom_range(7, 0), st, len));
        end
        wr_rd("R4 full symbol", 32'h0000_0000, 32'hF000_0000);
        // R5: two symbols, one in each column pair
        for (int i = 0; i < 60; i++) begin
            int ca = 2 * $urandom_range(1, 0);
            int cb = 2 * $urandom_range(1, 0) + 1;
            logic [31:0] m = sym_mask($urandom_range(1, 0), ca, 4'($urandom_range(15, 1)))
                           | sym_mask($urandom_range(1, 0), cb, 4'($urandom_range(15, 1)));
            wr_rd("R5 two symbols", $urandom, m);
        end
        // R6: inputs ignored while wr_en is low
        do_write(3, 32'h1234_5678, '0);
        @(negedge clk);
        wr_addr = 3; wr_data = 32'hDEAD_BEEF; wr_flip = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        wr_flip = '0;
        do_read(3);
        check("R6 no write when disabled", rd_data, 32'h1234_5678, rd_err, 1'b0);
        // R7: outputs hold while rd_en is low
        do_write(5, 32'hCAFE_F00D, 32'h0000_0030);
        do_read(5);
        rd_addr = 3;
        repeat (4) @(negedge clk);
        check("R7 hold", rd_data, 32'hCAFE_F00D, rd_err, 1'b1);
        // R8: same-cycle read and write
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3; wr_data = 32'h0BAD_C0DE; wr_flip = '0;
        rd_en = 1'b1; rd_addr = 3;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 old contents", rd_data, 32'h1234_5678, rd_err, 1'b0);
        do_read(3);
        check("R8 new contents", rd_data, 32'h0BAD_C0DE, rd_err, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule